// File: doc/BRIEF.md
# Video Mode Auto-Configuration Controller

This block keeps the control settings of a video capture front end in line with the current operating mode. Software programs the mode through a simple register write bus: a format code and a square-pixel flag in one register, and a two-bit input-source selector in another. From these the block derives nine analog-front-end control bits and a two-bit code that selects the video PLL frequency. The PLL frequency is always eight times the pixel rate.

Derived values change only on trigger events. The front-end bits are recomputed when the input-source register is written. The PLL code is recomputed when the format/square-pixel register is written, or when a format detector reports a change while the format code selects auto-detection. Between events, software may write either derived register directly, and that value holds until the next event. A global disable bit stops all automatic updates. Direct writes keep working while the disable bit is set.

Top module: `vmode_autocfg`

## Requirements
- R1: After reset, `afeCtrl` is 0x00C (composite) and `pllSel` is 0 (108 MHz). The format code is 0, square-pixel is off, the input source is 00, the remembered line count is 525 and auto-config is enabled.
- R2: One cycle after a write to the source register (address 0x401, source in data bits 2:1), `afeCtrl` takes the value for that source. The bit order is bit 8 down to bit 0: dual-ADC, droop ch3, droop ch2, clamp ch3, clamp ch2, gain-select ch3, gain-select ch1, half-bandwidth ch3, half-bandwidth ch2. The values are 00 composite = 0x00C, 01 Y/C = 0x000, 10 Y/C+audio = 0x148 and 11 component = 0x1F3.
- R3: One cycle after a write to the mode register (address 0x400, format code in bits 3:0, square-pixel in bit 4) with bit 4 clear, `pllSel` is 0 (108 MHz), whatever the line count.
- R4: One cycle after a mode register write with bit 4 set, `pllSel` is 1 (98.1818 MHz) for a 525-line format and 2 (118 MHz) for a 625-line format. Codes 1 to 3 are 525-line and codes 4 to 15 are 625-line. Code 0 uses the remembered detected line count.
- R5: While the format code is 0, a `detStrobe` pulse records `det625` (1 = 625 lines) as the line count and recomputes `pllSel` one cycle later. While the format code is nonzero, the strobe is ignored and `pllSel` does not change.
- R6: A write to address 0x410 (data bits 8:0) sets `afeCtrl`, and a write to address 0x411 (data bits 1:0) sets `pllSel`, one cycle later. These values hold through writes that are not triggers, until the next trigger for that field.
- R7: While bit 0 of address 0x402 is 1, no trigger changes `afeCtrl` or `pllSel`, and direct writes still apply. The strobe still records the line count in auto-detection mode.
- R8: When a PLL trigger and a direct write to 0x411 occur in the same cycle, the trigger's value wins.
- R9: A mode register write leaves `afeCtrl` unchanged, and a source register write leaves `pllSel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Register write address |
| wrData | input | 16 | Register write data |
| detStrobe | input | 1 | Format detector reports a change |
| det625 | input | 1 | Detected line count: 1 = 625, 0 = 525 |
| afeCtrl | output | 9 | Derived analog-front-end control bits |
| pllSel | output | 2 | PLL frequency code: 0 = 108, 1 = 98.1818, 2 = 118 MHz |

## Verification
Every result of this block is due exactly one clock after the bus write or detector strobe that causes it. A trigger event and a direct write both land at the edge that samples them. The driver applies one stimulus per cycle between clock edges, and pushes that cycle's expected `afeCtrl` and `pllSel` just after the edge. The monitor pops and compares at the following falling edge, so each result is checked in the one cycle it becomes valid. The tests for holds, ignored strobes and disabled triggers compare against the unchanged value in that same cycle, before the next stimulus can act.

// File: rtl/vmode_pkg.sv
package vmode_pkg;
  localparam int AFE_W = 9;
  localparam int PLL_W = 2;
  localparam int FMT_W = 4;
  localparam int FMT_LSB = 0;
  localparam int SQ_BIT = 4;
  localparam int SRC_LSB = 1;
  localparam int DIS_BIT = 0;

  typedef struct packed {
    logic wrMode;
    logic wrSrc;
    logic wrCtrl;
    logic wrAfe;
    logic wrPll;
    logic afeTrig;
    logic pllTrig;
    logic detTake;
  } strobe_t;

  // Front-end bits, MSB first: dual-ADC, droop3, droop2, clamp3, clamp2,
  // gainSel3, gainSel1, halfBw3, halfBw2
  function automatic logic [AFE_W-1:0] afeFor(input logic [1:0] src);
    case (src)
      2'b00:   afeFor = 9'b000001100;
      2'b01:   afeFor = 9'b000000000;
      2'b10:   afeFor = 9'b101001000;
      default: afeFor = 9'b111110011;
    endcase
  endfunction

  function automatic logic [PLL_W-1:0] pllFor(input logic sq, input logic is625);
    if (!sq)        pllFor = 2'd0;
    else if (is625) pllFor = 2'd2;
    else            pllFor = 2'd1;
  endfunction
endpackage

// File: rtl/vmode_ctrl.sv
module vmode_ctrl
  import vmode_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 12'h400,
  parameter logic [ADDR_W-1:0] SRC_ADDR = 12'h401,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h402,
  parameter logic [ADDR_W-1:0] AFE_ADDR = 12'h410,
  parameter logic [ADDR_W-1:0] PLL_ADDR = 12'h411,
  parameter int FMT_625_MIN = 4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              detStrobe,
  input  logic              det625,
  input  logic [FMT_W-1:0]  fmtReg,
  input  logic              sqReg,
  input  logic              lineReg,
  input  logic              disReg,
  output strobe_t           stb,
  output logic              sqNow,
  output logic              lineNow,
  output logic              lineNext
);
  logic [FMT_W-1:0] fmtNow;
  logic autoMode;

  always_comb begin
    stb.wrMode = wrEn && (wrAddr == MODE_ADDR);
    stb.wrSrc  = wrEn && (wrAddr == SRC_ADDR);
    stb.wrCtrl = wrEn && (wrAddr == CTRL_ADDR);
    stb.wrAfe  = wrEn && (wrAddr == AFE_ADDR);
    stb.wrPll  = wrEn && (wrAddr == PLL_ADDR);

    fmtNow   = stb.wrMode ? wrData[FMT_LSB +: FMT_W] : fmtReg;
    sqNow    = stb.wrMode ? wrData[SQ_BIT] : sqReg;
    autoMode = (fmtNow == '0);

    stb.detTake = detStrobe && autoMode;
    lineNext    = stb.detTake ? det625 : lineReg;
    lineNow     = autoMode ? lineNext : (fmtNow >= FMT_W'(FMT_625_MIN));

    stb.afeTrig = !disReg && stb.wrSrc;
    stb.pllTrig = !disReg && (stb.wrMode || stb.detTake);
  end
endmodule

// File: rtl/vmode_datapath.sv
module vmode_datapath
  import vmode_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sqNow,
  input  logic              lineNow,
  input  logic              lineNext,
  output logic [FMT_W-1:0]  fmtReg,
  output logic              sqReg,
  output logic              lineReg,
  output logic              disReg,
  output logic [AFE_W-1:0]  afeCtrl,
  output logic [PLL_W-1:0]  pllSel
);
  logic [1:0] srcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtReg  <= '0;
      sqReg   <= 1'b0;
      lineReg <= 1'b0;
      disReg  <= 1'b0;
      srcReg  <= 2'b00;
      afeCtrl <= afeFor(2'b00);
      pllSel  <= pllFor(1'b0, 1'b0);
    end else begin
      if (stb.wrMode) begin
        fmtReg <= wrData[FMT_LSB +: FMT_W];
        sqReg  <= wrData[SQ_BIT];
      end
      if (stb.wrSrc)  srcReg <= wrData[SRC_LSB +: 2];
      if (stb.wrCtrl) disReg <= wrData[DIS_BIT];
      lineReg <= lineNext;

      if (stb.afeTrig)    afeCtrl <= afeFor(wrData[SRC_LSB +: 2]);
      else if (stb.wrAfe) afeCtrl <= wrData[AFE_W-1:0];

      if (stb.pllTrig)    pllSel <= pllFor(sqNow, lineNow);
      else if (stb.wrPll) pllSel <= wrData[PLL_W-1:0];
    end
  end

  // R7
  dis_afe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (disReg && !stb.wrCtrl && !stb.wrAfe) |=> $stable(afeCtrl));
  // R7
  dis_pll_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (disReg && !stb.wrCtrl && !stb.wrPll) |=> $stable(pllSel));
  // R2
  src_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.afeTrig |=> (afeCtrl == afeFor(srcReg)));
  // R3
  nonsq_pll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pllTrig && !sqNow) |=> (pllSel == 2'd0));
  // R5
  det_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrMode && !stb.wrPll && fmtReg != '0) |=> $stable(pllSel));
  // R9
  src_keeps_pll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSrc && !stb.detTake) |=> $stable(pllSel));
endmodule

// File: rtl/vmode_autocfg.sv
module vmode_autocfg
  import vmode_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              detStrobe,
  input  logic              det625,
  output logic [AFE_W-1:0]  afeCtrl,
  output logic [PLL_W-1:0]  pllSel
);
  strobe_t stb;
  logic [FMT_W-1:0] fmtReg;
  logic sqReg, lineReg, disReg, sqNow, lineNow, lineNext;

  vmode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .detStrobe(detStrobe), .det625(det625),
    .fmtReg(fmtReg), .sqReg(sqReg), .lineReg(lineReg), .disReg(disReg),
    .stb(stb), .sqNow(sqNow), .lineNow(lineNow), .lineNext(lineNext)
  );

  vmode_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .sqNow(sqNow), .lineNow(lineNow), .lineNext(lineNext),
    .fmtReg(fmtReg), .sqReg(sqReg), .lineReg(lineReg), .disReg(disReg),
    .afeCtrl(afeCtrl), .pllSel(pllSel)
  );
endmodule

// File: tb/vmode_autocfg_tb.sv
module vmode_autocfg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [15:0] wrData = '0;
  logic detStrobe = 1'b0;
  logic det625 = 1'b0;
  logic [8:0] afeCtrl;
  logic [1:0] pllSel;

  int runCnt = 0;
  int failCnt = 0;

  typedef struct {
    logic [8:0] afe;
    logic [1:0] pll;
    string tag;
  } exp_t;
  exp_t expQ[$];

  localparam logic [11:0] A_MODE = 12'h400, A_SRC = 12'h401, A_CTRL = 12'h402,
                          A_AFE = 12'h410, A_PLL = 12'h411;

  always #2.5 clk = ~clk;

  vmode_autocfg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .detStrobe(detStrobe), .det625(det625), .afeCtrl(afeCtrl), .pllSel(pllSel)
  );

  // monitor
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      runCnt++;
      if (afeCtrl !== e.afe || pllSel !== e.pll) begin
        failCnt++;
        $display("FAIL %s: afe=%h pll=%0d expected afe=%h pll=%0d",
                 e.tag, afeCtrl, pllSel, e.afe, e.pll);
      end
    end
  end

  task automatic pushExp(input logic [8:0] a, input logic [1:0] p, input string tag);
    exp_t e;
    e.afe = a; e.pll = p; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic step(input logic we, input logic [11:0] ad, input logic [15:0] d,
                      input logic stbIn, input logic l625,
                      input logic [8:0] eAfe, input logic [1:0] ePll, input string tag);
    @(negedge clk);
    wrEn = we; wrAddr = ad; wrData = d; detStrobe = stbIn; det625 = l625;
    @(posedge clk);
    #1;
    wrEn = 1'b0; detStrobe = 1'b0;
    pushExp(eAfe, ePll, tag);
  endtask

  task automatic wr(input logic [11:0] ad, input logic [15:0] d,
                    input logic [8:0] eAfe, input logic [1:0] ePll, input string tag);
    step(1'b1, ad, d, 1'b0, 1'b0, eAfe, ePll, tag);
  endtask

  task automatic det(input logic l625, input logic [8:0] eAfe, input logic [1:0] ePll,
                     input string tag);
    step(1'b0, '0, '0, 1'b1, l625, eAfe, ePll, tag);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    pushExp(9'h00C, 2'd0, "R1 reset");

    wr(A_SRC, 16'h0002, 9'h000, 2'd0, "R2 Y/C");
    wr(A_SRC, 16'h0004, 9'h148, 2'd0, "R2 Y/C+audio");
    wr(A_SRC, 16'h0006, 9'h1F3, 2'd0, "R2 component");
    wr(A_SRC, 16'h0000, 9'h00C, 2'd0, "R2 composite");
    wr(A_MODE, 16'h0011, 9'h00C, 2'd1, "R4 sq 525 code1");
    wr(A_MODE, 16'h0015, 9'h00C, 2'd2, "R4 sq 625 code5");
    wr(A_MODE, 16'h0005, 9'h00C, 2'd0, "R3 non-square");
    wr(A_MODE, 16'h0010, 9'h00C, 2'd1, "R4 auto line 525");
    det(1'b1, 9'h00C, 2'd2, "R5 detect 625");
    det(1'b0, 9'h00C, 2'd1, "R5 detect 525");
    wr(A_MODE, 16'h0013, 9'h00C, 2'd1, "R4 sq code3");
    det(1'b1, 9'h00C, 2'd1, "R5 strobe ignored");
    wr(A_MODE, 16'h0010, 9'h00C, 2'd1, "R5 line not recorded");
    wr(A_AFE, 16'h01AB, 9'h1AB, 2'd1, "R6 afe override");
    wr(A_PLL, 16'h0002, 9'h1AB, 2'd2, "R6 pll override");
    wr(A_CTRL, 16'h0000, 9'h1AB, 2'd2, "R6 override holds");
    wr(A_MODE, 16'h0012, 9'h1AB, 2'd1, "R9 mode keeps afe");
    wr(A_SRC, 16'h0002, 9'h000, 2'd1, "R9 src keeps pll / R6 retrigger");
    wr(A_CTRL, 16'h0001, 9'h000, 2'd1, "R7 disable");
    wr(A_SRC, 16'h0006, 9'h000, 2'd1, "R7 src trigger blocked");
    wr(A_MODE, 16'h0014, 9'h000, 2'd1, "R7 mode trigger blocked");
    wr(A_AFE, 16'h0055, 9'h055, 2'd1, "R7 direct write works");
    wr(A_CTRL, 16'h0000, 9'h055, 2'd1, "R7 re-enable");
    wr(A_MODE, 16'h0014, 9'h055, 2'd2, "R4 sq code4");
    wr(A_SRC, 16'h0006, 9'h1F3, 2'd2, "R2 component again");
    wr(A_MODE, 16'h0010, 9'h1F3, 2'd1, "R4 auto line 525");
    step(1'b1, A_PLL, 16'h0000, 1'b1, 1'b1, 9'h1F3, 2'd2, "R8 trigger beats write");
    wr(A_CTRL, 16'h0001, 9'h1F3, 2'd2, "R7 disable again");
    det(1'b0, 9'h1F3, 2'd2, "R7 strobe blocked");
    wr(A_CTRL, 16'h0000, 9'h1F3, 2'd2, "R7 re-enable");
    wr(A_MODE, 16'h0010, 9'h1F3, 2'd1, "R7 line recorded while disabled");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      failCnt++;
      $display("FAIL queue: %0d left expected 0", expQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule